// File: doc/BRIEF.md
# Linear and Circular Address Generator

This block forms the effective address of a load or store from a base register value, a signed offset and the operand size. The offset is first scaled to bytes by the operand size. The scaled offset is then added to the base in one of three ways. In linear mode every address bit may change. In either of two circular modes only the low bits of the address may change, so the result wraps inside a power-of-two buffer that holds the base.

A configuration register, written through a clocked write port, holds a two-bit mode field for each of the eight base registers that may address circularly, along with two block-size fields. The request side is purely combinational. It returns the updated base, which is written back in both forms. It also returns the address used for the access. A pre-modify request uses the updated value for the access, and a post-modify request uses the old base. Memory access, alignment checks and register storage belong to other blocks.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset the configuration register is all zero, so every request behaves as linear until a write lands.
- R2: `req_size` scales the offset: code 0 (byte) shifts left by 0, code 1 (halfword) by 1, code 2 (word) by 2, code 3 (doubleword) by 3. The 16-bit offset is sign-extended before the shift.
- R3: In linear mode `rsp_newbase` equals `req_base` plus the scaled offset, modulo 2^32.
- R4: The mode field for base register i (i from 0 to 7) sits at `cfg_wdata[2i+1:2i]`. Code 00 selects linear, 01 selects circular with block size A, 10 selects circular with block size B, and 11 is reserved and acts as linear. Base register indices 8 to 31 are always linear.
- R5: Block size A is `cfg_wdata[20:16]` and block size B is `cfg_wdata[25:21]`. For a size value N, a circular access changes only bits 0..N of the address. Bits 0..N take the low bits of base plus scaled offset, and all higher bits keep their value from `req_base`. The buffer is 2^(N+1) bytes.
- R6: A negative offset in a circular mode wraps downward. It moves from the bottom of the buffer to its top.
- R7: With `req_pre`=1, `rsp_addr` equals `rsp_newbase`. With `req_pre`=0, `rsp_addr` equals `req_base`. In both cases `rsp_newbase` is the updated value.
- R8: A configuration write is sampled at a rising clock edge when `cfg_we`=1, and it governs requests from that edge on. Without `cfg_we` the register holds its value.
- R9: A circular block size of 31 spans the whole 32-bit address, so the result matches linear mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 26 | Configuration value: mode fields and two block sizes |
| req_base | input | 32 | Current base register value |
| req_offset | input | 16 | Signed offset in operand units |
| req_size | input | 2 | Operand size code |
| req_breg | input | 5 | Index of the base register |
| req_pre | input | 1 | 1 selects pre-modify, 0 selects post-modify |
| rsp_addr | output | 32 | Address used for the access |
| rsp_newbase | output | 32 | Updated base value to write back |

## Verification
Because the datapath is combinational, a wrong mode decode or wrong mask shows up on `rsp_newbase` in the same cycle as the request. It appears as high bits that changed when they should have held, or as a result that failed to wrap. A corrupted configuration register persists, so it shows on the first request that uses the affected base register after the bad write, and on every such request after that. The reference model keeps its own copy of the configuration and compares both outputs on every cycle, including the cycle in which a write is pending. This exposes a register that updates a cycle early or a cycle late.

// File: rtl/agen_pkg.sv
package agen_pkg;

  localparam int MODE_W = 2;
  localparam int BSZ_W  = 5;

  typedef enum logic [1:0] {
    AM_LINEAR = 2'b00,
    AM_CIRC_A = 2'b01,
    AM_CIRC_B = 2'b10,
    AM_RSVD   = 2'b11
  } amode_e;

  function automatic logic is_circular(amode_e m);
    return (m == AM_CIRC_A) || (m == AM_CIRC_B);
  endfunction

endpackage

// File: rtl/agen_mode_reg.sv
module agen_mode_reg #(
  parameter int NUM_CIRC = 8,
  localparam int FLD_W = NUM_CIRC * agen_pkg::MODE_W,
  localparam int CFG_W = FLD_W + 2 * agen_pkg::BSZ_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [CFG_W-1:0]           wdata,
  output logic [FLD_W-1:0]           mode_vec,
  output logic [agen_pkg::BSZ_W-1:0] bsz_a,
  output logic [agen_pkg::BSZ_W-1:0] bsz_b
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata;
  end

  assign mode_vec = cfg_q[FLD_W-1:0];
  assign bsz_a    = cfg_q[FLD_W +: agen_pkg::BSZ_W];
  assign bsz_b    = cfg_q[FLD_W + agen_pkg::BSZ_W +: agen_pkg::BSZ_W];

  // R8: a write lands on the sampling edge
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    we |=> cfg_q == $past(wdata));

  // R8: no write, no change
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg_q));

endmodule

// File: rtl/agen_mode_sel.sv
module agen_mode_sel #(
  parameter int NUM_CIRC = 8,
  parameter int IDX_W    = 5,
  parameter int ADDR_W   = 32,
  localparam int FLD_W = NUM_CIRC * agen_pkg::MODE_W
) (
  input  logic [IDX_W-1:0]           breg,
  input  logic [FLD_W-1:0]           mode_vec,
  input  logic [agen_pkg::BSZ_W-1:0] bsz_a,
  input  logic [agen_pkg::BSZ_W-1:0] bsz_b,
  output agen_pkg::amode_e           mode,
  output logic                       circ,
  output logic [ADDR_W-1:0]          mask
);
  import agen_pkg::*;

  amode_e field [NUM_CIRC];
  logic [BSZ_W-1:0] span;

  for (genvar g = 0; g < NUM_CIRC; g++) begin : g_field
    assign field[g] = amode_e'(mode_vec[g*MODE_W +: MODE_W]);
  end

  // Bits 0..n set, everything above clear
  function automatic logic [ADDR_W-1:0] span_mask(logic [BSZ_W-1:0] n);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i <= int'(n));
    return m;
  endfunction

  always_comb begin
    mode = AM_LINEAR;
    for (int i = 0; i < NUM_CIRC; i++)
      if (breg == IDX_W'(i)) mode = field[i];
  end

  assign circ = is_circular(mode);
  assign span = (mode == AM_CIRC_B) ? bsz_b : bsz_a;
  assign mask = circ ? span_mask(span) : '1;

endmodule

// File: rtl/agen_calc.sv
module agen_calc #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] mask,
  input  logic              pre,
  output logic [ADDR_W-1:0] scaled,
  output logic [ADDR_W-1:0] sum,
  output logic [ADDR_W-1:0] newbase,
  output logic [ADDR_W-1:0] addr
);

  // Sign-extend the offset and turn operand units into bytes
  function automatic logic [ADDR_W-1:0] scale_off(logic [OFF_W-1:0] off,
                                                  logic [1:0] sz);
    logic signed [OFF_W-1:0]  s;
    logic        [ADDR_W-1:0] ext;
    s   = $signed(off);
    ext = ADDR_W'(s);
    return ext << sz;
  endfunction

  // Keep the base outside the window, take the sum inside it
  function automatic logic [ADDR_W-1:0] merge(logic [ADDR_W-1:0] b,
                                              logic [ADDR_W-1:0] s,
                                              logic [ADDR_W-1:0] m);
    return (b & ~m) | (s & m);
  endfunction

  assign scaled  = scale_off(offset, size);
  assign sum     = base + scaled;
  assign newbase = merge(base, sum, mask);
  assign addr    = pre ? newbase : base;

endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int NUM_CIRC = 8,
  parameter int IDX_W    = 5,
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [NUM_CIRC*agen_pkg::MODE_W+2*agen_pkg::BSZ_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0]          req_base,
  input  logic [OFF_W-1:0]           req_offset,
  input  logic [1:0]                 req_size,
  input  logic [IDX_W-1:0]           req_breg,
  input  logic                       req_pre,
  output logic [ADDR_W-1:0]          rsp_addr,
  output logic [ADDR_W-1:0]          rsp_newbase
);
  import agen_pkg::*;

  localparam int FLD_W = NUM_CIRC * MODE_W;

  logic [FLD_W-1:0]  mode_vec;
  logic [BSZ_W-1:0]  bsz_a, bsz_b;
  amode_e            sel_mode;
  logic              circ_active;
  logic [ADDR_W-1:0] win_mask, scaled, raw_sum;

  agen_mode_reg #(.NUM_CIRC(NUM_CIRC)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .mode_vec(mode_vec), .bsz_a(bsz_a), .bsz_b(bsz_b)
  );

  agen_mode_sel #(.NUM_CIRC(NUM_CIRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_sel (
    .breg(req_breg), .mode_vec(mode_vec), .bsz_a(bsz_a), .bsz_b(bsz_b),
    .mode(sel_mode), .circ(circ_active), .mask(win_mask)
  );

  agen_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_calc (
    .base(req_base), .offset(req_offset), .size(req_size), .mask(win_mask),
    .pre(req_pre), .scaled(scaled), .sum(raw_sum),
    .newbase(rsp_newbase), .addr(rsp_addr)
  );

  assert_post_base_R7: assert property (@(posedge clk) disable iff (rst)
    !req_pre |-> rsp_addr == req_base);

  assert_pre_update_R7: assert property (@(posedge clk) disable iff (rst)
    req_pre |-> rsp_addr == rsp_newbase);

  assert_high_kept_R5: assert property (@(posedge clk) disable iff (rst)
    circ_active |-> ((rsp_newbase ^ req_base) & ~win_mask) == '0);

  assert_mask_shape_R5: assert property (@(posedge clk) disable iff (rst)
    circ_active |-> (win_mask[0] && ((win_mask + 1'b1) & win_mask) == '0));

  assert_linear_sum_R3: assert property (@(posedge clk) disable iff (rst)
    !circ_active |-> rsp_newbase == raw_sum);

  assert_reserved_linear_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_mode == AM_RSVD) |-> !circ_active);

  assert_scale_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (scaled & ~({ADDR_W{1'b1}} << req_size)) == '0);

endmodule

// File: tb/tb_addr_gen_unit.sv
module tb_addr_gen_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [25:0] cfg_wdata = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [4:0]  req_breg = '0;
  logic        req_pre = 1'b0;
  logic [31:0] rsp_addr, rsp_newbase;

  int compared = 0;
  int mismatched = 0;
  logic [25:0] m_cfg = '0;

  always #5 clk = ~clk;

  addr_gen_unit dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_base(req_base), .req_offset(req_offset), .req_size(req_size),
    .req_breg(req_breg), .req_pre(req_pre),
    .rsp_addr(rsp_addr), .rsp_newbase(rsp_newbase)
  );

  // Model copy of the configuration, updated on the same edge as the design
  always @(posedge clk) begin
    if (rst)         m_cfg <= '0;
    else if (cfg_we) m_cfg <= cfg_wdata;
  end

  function automatic logic [31:0] ref_update(logic [31:0] b, logic [15:0] off,
                                             logic [1:0] sz, logic [4:0] r,
                                             logic [25:0] c);
    longint step, total, blen, lo, nl;
    int code, n;
    step = longint'($signed(off)) * (longint'(1) << sz);
    code = (r < 8) ? int'(c[2*r +: 2]) : 0;
    if (code == 1)      n = int'(c[20:16]);
    else if (code == 2) n = int'(c[25:21]);
    else                n = -1;
    if (n < 0) begin
      total = longint'(b) + step;
    end else begin
      blen = longint'(1) << (n + 1);
      lo   = longint'(b) % blen;
      nl   = (lo + step) % blen;
      if (nl < 0) nl = nl + blen;
      total = longint'(b) - lo + nl;
    end
    return total[31:0];
  endfunction

  task automatic check(string tag);
    logic [31:0] exp_nb, exp_ad;
    exp_nb = ref_update(req_base, req_offset, req_size, req_breg, m_cfg);
    exp_ad = req_pre ? exp_nb : req_base;
    compared++;
    if (rsp_newbase !== exp_nb) begin
      mismatched++;
      $display("FAIL %s newbase actual=%h expected=%h", tag, rsp_newbase, exp_nb);
    end
    compared++;
    if (rsp_addr !== exp_ad) begin
      mismatched++;
      $display("FAIL %s addr actual=%h expected=%h", tag, rsp_addr, exp_ad);
    end
  endtask

  // Drive at the falling edge, compare just before the next rising edge
  task automatic apply(string tag, logic [31:0] b, logic [15:0] off,
                       logic [1:0] sz, logic [4:0] r, logic pre);
    @(negedge clk);
    req_base = b; req_offset = off; req_size = sz; req_breg = r; req_pre = pre;
    #4;
    check(tag);
  endtask

  task automatic write_cfg(logic [25:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    #4;
    check("R8");
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    logic [25:0] cfg;
    // R1: config writes during reset are dropped, all linear
    cfg_we = 1'b1; cfg_wdata = 26'h3FF_FFFF;
    repeat (3) @(posedge clk);
    apply("R1", 32'h1000_000C, 16'h0004, 2'd2, 5'd1, 1'b1);
    @(negedge clk); rst = 1'b0; cfg_we = 1'b0;
    apply("R1", 32'h1000_000C, 16'h0004, 2'd2, 5'd1, 1'b1);
    // R2/R3: linear scaling for each size code
    for (int s = 0; s < 4; s++) begin
      apply("R2", 32'h0000_1000, 16'h0003, 2'(s), 5'd0, 1'b1);
      apply("R3", 32'hFFFF_FFF0, 16'hFFFE, 2'(s), 5'd20, 1'b0);
    end
    // R7: pre versus post
    apply("R7", 32'h2000_0000, 16'h0010, 2'd0, 5'd4, 1'b0);
    apply("R7", 32'h2000_0000, 16'h0010, 2'd0, 5'd4, 1'b1);
    // R4/R5: reg1 circ A (N=3), reg2 circ B (N=7), reg3 reserved
    cfg = '0;
    cfg[3:2] = 2'b01; cfg[5:4] = 2'b10; cfg[7:6] = 2'b11; cfg[15:14] = 2'b01;
    cfg[20:16] = 5'd3; cfg[25:21] = 5'd7;
    write_cfg(cfg);
    apply("R5", 32'h1000_000C, 16'h0002, 2'd2, 5'd1, 1'b1);
    apply("R5", 32'h1000_00F8, 16'h0003, 2'd3, 5'd2, 1'b0);
    apply("R5", 32'h1000_000C, 16'h0002, 2'd2, 5'd7, 1'b1);
    apply("R4", 32'h1000_000C, 16'h0002, 2'd2, 5'd3, 1'b1);
    apply("R4", 32'h1000_000C, 16'h0002, 2'd2, 5'd9, 1'b1);
    apply("R4", 32'h1000_000C, 16'h0002, 2'd2, 5'd0, 1'b1);
    // R6: negative offsets wrap downward
    apply("R6", 32'h1000_0004, 16'hFFFD, 2'd0, 5'd1, 1'b1);
    apply("R6", 32'h1000_0004, 16'hFFFE, 2'd2, 5'd1, 1'b1);
    apply("R6", 32'h3000_0010, 16'hFFFF, 2'd3, 5'd2, 1'b0);
    // R9: full-width block behaves as linear
    cfg[25:21] = 5'd31;
    write_cfg(cfg);
    apply("R9", 32'hFFFF_FFF8, 16'h0004, 2'd1, 5'd2, 1'b1);
    apply("R9", 32'h0000_0004, 16'hFFF0, 2'd0, 5'd2, 1'b1);
    // R8: register holds with no write
    apply("R8", 32'h1000_000C, 16'h0002, 2'd2, 5'd1, 1'b1);
    // Mixed sweep: new configuration now and then
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) write_cfg(26'($urandom));
      apply("R5", $urandom, 16'($urandom), 2'($urandom), 5'($urandom % 12),
            1'($urandom));
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule